// File: doc/BRIEF.md
# Serial Program/Verify Target Receiver

This block is the device-side end of a two-wire programming port. An external host drives a serial clock and a data line; the block runs from a faster system clock. It brings both lines in through two-flop synchronizers and finds the clock edges from the synchronized copy. It then collects 6-bit commands, with the data bit taken on each falling edge, least significant bit first.

A finished command is passed to the memory side with a one-cycle strobe. If the command code matches the load or the read encoding, a 16-clock data segment follows. The segment has a start slot, then 14 data slots, then a stop slot. A load collects 14 bits, LSb first, and hands them over with a strobe. A read captures the memory word and drives it back, LSb first. The block enables its data output only inside the read window and keeps it released everywhere else. Any other command code has no data segment, and the block goes straight back to collecting the next command.

The synchronous active-low reset is held low whenever programming mode is not active.

Top module: `serprog_target`

## Requirements
- R1: Six consecutive falling edges of the serial clock form one command. The bit sampled at the first edge is bit 0 of `cmd_code`. Within a few system clocks after the sixth edge, `cmd_stb` pulses for one cycle with the assembled code.
- R2: A command whose code equals neither `LOAD_CODE` (default 6'h02) nor `READ_CODE` (default 6'h04) has no data segment. The next six falling edges form the next command.
- R3: After a load command, the bits sampled on falling edges 2 to 15 of the following 16-clock segment form `ld_data` bits 0 to 13. After the 16th falling edge, `ld_stb` pulses once with that word, and the block returns to command reception.
- R4: Data sampled on the start slot (falling edge 1) and the stop slot (falling edge 16) of a load segment does not change `ld_data`.
- R5: During a read segment, `sdat_oe` rises after the 2nd rising edge of the serial clock and falls after the 16th rising edge. It is high from rising edge 2 through rising edge 15.
- R6: A read captures `rd_data` at the 1st rising edge of its segment. After rising edge k+2, `sdat_out` carries bit k of the captured word, for k = 0 to 13.
- R7: `sdat_oe` stays low during command reception and during the whole of a load segment.
- R8: While `rst_n` is low, `sdat_oe`, `sdat_out`, `cmd_stb` and `ld_stb` are low.
- R9: A reset in the middle of a command drops the partial bits. The next six falling edges form a fresh command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset, low outside programming mode |
| sclk_in | input | 1 | Host serial clock, asynchronous |
| sdat_in | input | 1 | Serial data from the host, asynchronous |
| sdat_out | output | 1 | Serial data driven back during a read window |
| sdat_oe | output | 1 | Output enable for the data pad driver |
| cmd_stb | output | 1 | One-cycle pulse when a command is complete |
| cmd_code | output | 6 | Code of the last completed command |
| ld_stb | output | 1 | One-cycle pulse when a load word is complete |
| ld_data | output | 14 | Last loaded data word |
| rd_data | input | 14 | Word from memory, captured at the start of a read segment |

## Verification
Two events meet directly at the end of a load segment. The stop-slot falling edge emits `ld_stb` and hands control back to command reception. The next command then starts with no idle gap between them. The bench provokes this by sending a load and a no-data command back to back at the minimum host spacing. It passes only when both the word and the following code arrive intact and each strobe is counted exactly once. It also runs a read right after a load and checks that the enable does not spill over from one segment into the other.

// File: rtl/serprog_pkg.sv
// Shared types for the serial program/verify target.
package serprog_pkg;
    typedef enum logic [1:0] {
        SEG_NONE,
        SEG_LOAD,
        SEG_READ
    } seg_kind_t;

    typedef enum logic {
        ST_CMD,
        ST_DATA
    } eng_state_t;
endpackage

// File: rtl/serprog_sync.sv
// Brings the host clock and data into the system clock domain.
// Assumes the host clock stays high and low for at least three system
// clocks each. Data and clock pass through equal-depth synchronizers,
// so the data seen with an edge pulse is the value that was present at that edge.
module serprog_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sdat_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdat_s
);
    logic [2:0] ck_q;
    logic [1:0] dt_q;

    // Two-flop synchronizers plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_q <= '0;
            dt_q <= '0;
        end else begin
            ck_q <= {ck_q[1:0], sclk_in};
            dt_q <= {dt_q[0], sdat_in};
        end
    end

    assign sclk_rise = ck_q[1] & ~ck_q[2];
    assign sclk_fall = ~ck_q[1] & ck_q[2];
    assign sdat_s    = dt_q[1];
endmodule

// File: rtl/serprog_classify.sv
// Maps a command code to the kind of data segment that follows it.
// Pure combinational logic; the encodings are parameters.
module serprog_classify
    import serprog_pkg::*;
#(
    parameter int          CMD_W     = 6,
    parameter logic [CMD_W-1:0] LOAD_CODE = 6'h02,
    parameter logic [CMD_W-1:0] READ_CODE = 6'h04
) (
    input  logic [CMD_W-1:0] code,
    output seg_kind_t        kind
);
    // Decode the code into load, read or no segment.
    always_comb begin
        if (code == LOAD_CODE)      kind = SEG_LOAD;
        else if (code == READ_CODE) kind = SEG_READ;
        else                        kind = SEG_NONE;
    end
endmodule

// File: rtl/serprog_engine.sv
// Command and data-segment sequencer. It consumes edge pulses from the
// synchronizer, shifts commands and load words in LSb first on falling
// edges, and launches read bits on rising edges. It assumes a rising
// edge and a falling edge never come in the same system cycle.
module serprog_engine
    import serprog_pkg::*;
#(
    parameter int          CMD_W     = 6,
    parameter int          DATA_W    = 14,
    parameter logic [CMD_W-1:0] LOAD_CODE = 6'h02,
    parameter logic [CMD_W-1:0] READ_CODE = 6'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdat_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sdat_out,
    output logic              sdat_oe,
    output logic              cmd_stb,
    output logic [CMD_W-1:0]  cmd_code,
    output logic              ld_stb,
    output logic [DATA_W-1:0] ld_data
);
    localparam int SEG_CLKS = DATA_W + 2;
    localparam int MAX_CNT  = (SEG_CLKS > CMD_W) ? SEG_CLKS : CMD_W;
    localparam int CNT_W    = $clog2(MAX_CNT);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] SEG_LAST  = CNT_W'(SEG_CLKS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W);

    eng_state_t        state_q;
    seg_kind_t         kind_q;
    seg_kind_t         nxt_kind;
    logic [CNT_W-1:0]  cnt_q;
    logic [CMD_W-1:0]  cmd_sr_q;
    logic [CMD_W-1:0]  cmd_nxt;
    logic [DATA_W-1:0] dat_sr_q;

    assign cmd_nxt = {sdat_s, cmd_sr_q[CMD_W-1:1]};

    serprog_classify #(
        .CMD_W    (CMD_W),
        .LOAD_CODE(LOAD_CODE),
        .READ_CODE(READ_CODE)
    ) u_cls (
        .code(cmd_nxt),
        .kind(nxt_kind)
    );

    // Sequencer: command shift, segment slot count, load capture, read launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_CMD;
            kind_q   <= SEG_NONE;
            cnt_q    <= '0;
            cmd_sr_q <= '0;
            dat_sr_q <= '0;
            cmd_stb  <= 1'b0;
            cmd_code <= '0;
            ld_stb   <= 1'b0;
            ld_data  <= '0;
            sdat_oe  <= 1'b0;
            sdat_out <= 1'b0;
        end else begin
            cmd_stb <= 1'b0;
            ld_stb  <= 1'b0;
            case (state_q)
                ST_CMD: begin
                    if (sclk_fall) begin
                        cmd_sr_q <= cmd_nxt;
                        if (cnt_q == CMD_LAST) begin
                            cnt_q    <= '0;
                            cmd_stb  <= 1'b1;
                            cmd_code <= cmd_nxt;
                            kind_q   <= nxt_kind;
                            if (nxt_kind != SEG_NONE) state_q <= ST_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    if (sclk_rise && kind_q == SEG_READ) begin
                        if (cnt_q == '0) begin
                            dat_sr_q <= rd_data;
                        end else if (cnt_q <= DATA_LAST) begin
                            sdat_oe  <= 1'b1;
                            sdat_out <= dat_sr_q[0];
                            dat_sr_q <= dat_sr_q >> 1;
                        end else begin
                            sdat_oe  <= 1'b0;
                            sdat_out <= 1'b0;
                        end
                    end
                    if (sclk_fall) begin
                        if (kind_q == SEG_LOAD && cnt_q != '0 && cnt_q <= DATA_LAST)
                            dat_sr_q <= {sdat_s, dat_sr_q[DATA_W-1:1]};
                        if (cnt_q == SEG_LAST) begin
                            cnt_q   <= '0;
                            state_q <= ST_CMD;
                            if (kind_q == SEG_LOAD) begin
                                ld_stb  <= 1'b1;
                                ld_data <= dat_sr_q;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // R7
    oe_in_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdat_oe |-> (state_q == ST_DATA && kind_q == SEG_READ));

    // R3
    ld_from_segment_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |-> ($past(state_q) == ST_DATA && state_q == ST_CMD));
endmodule

// File: rtl/serprog_target.sv
// Top of the serial program/verify target receiver. It joins the
// synchronizer and the sequencer. The pad tri-state buffer sits outside:
// the pad is driven with sdat_out when sdat_oe is high.
module serprog_target #(
    parameter int          CMD_W     = 6,
    parameter int          DATA_W    = 14,
    parameter logic [CMD_W-1:0] LOAD_CODE = 6'h02,
    parameter logic [CMD_W-1:0] READ_CODE = 6'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              sdat_in,
    output logic              sdat_out,
    output logic              sdat_oe,
    output logic              cmd_stb,
    output logic [CMD_W-1:0]  cmd_code,
    output logic              ld_stb,
    output logic [DATA_W-1:0] ld_data,
    input  logic [DATA_W-1:0] rd_data
);
    logic sclk_rise;
    logic sclk_fall;
    logic sdat_s;

    serprog_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_in  (sclk_in),
        .sdat_in  (sdat_in),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .sdat_s   (sdat_s)
    );

    serprog_engine #(
        .CMD_W    (CMD_W),
        .DATA_W   (DATA_W),
        .LOAD_CODE(LOAD_CODE),
        .READ_CODE(READ_CODE)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .sdat_s   (sdat_s),
        .rd_data  (rd_data),
        .sdat_out (sdat_out),
        .sdat_oe  (sdat_oe),
        .cmd_stb  (cmd_stb),
        .cmd_code (cmd_code),
        .ld_stb   (ld_stb),
        .ld_data  (ld_data)
    );

    // R1
    cmd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> $past(sclk_fall));

    // R5
    oe_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdat_oe) |-> $past(sclk_rise));

    // R5
    oe_off_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sdat_oe) && $past(rst_n)) |-> $past(sclk_rise));

    // R3
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_stb && ld_stb));

    // R8
    always_ff @(posedge clk) begin
        if (rst_n && $past(!rst_n))
            reset_quiet_chk: assert (!sdat_oe && !sdat_out && !cmd_stb && !ld_stb);
    end
endmodule

// File: tb/sim_serprog_target.sv
module sim_serprog_target;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b0;
    logic        sdat_in = 1'b0;
    logic        sdat_out, sdat_oe, cmd_stb, ld_stb;
    logic [5:0]  cmd_code;
    logic [13:0] ld_data;
    logic [13:0] rd_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int n_cmd   = 0;
    int n_ld    = 0;
    logic [5:0]  last_cmd = '0;
    logic [13:0] last_ld  = '0;
    logic hi_oe, hi_dout;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serprog_target u0 (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdat_in(sdat_in),
        .sdat_out(sdat_out), .sdat_oe(sdat_oe), .cmd_stb(cmd_stb),
        .cmd_code(cmd_code), .ld_stb(ld_stb), .ld_data(ld_data),
        .rd_data(rd_data)
    );

    always @(negedge clk) begin
        if (cmd_stb) begin n_cmd++; last_cmd = cmd_code; end
        if (ld_stb)  begin n_ld++;  last_ld  = ld_data;  end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One host clock pulse; outputs sampled at the end of the high phase.
    task automatic host_clk(input logic d);
        sdat_in = d;
        sclk_in = 1'b1;
        repeat (HALF) @(negedge clk);
        hi_oe = sdat_oe;
        hi_dout = sdat_out;
        sclk_in = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [5:0] c);
        for (int i = 0; i < 6; i++) host_clk(c[i]);
    endtask

    task automatic t_reset();
        chk(sdat_oe == 1'b0, "R8 oe", sdat_oe, 0);
        chk(sdat_out == 1'b0, "R8 dout", sdat_out, 0);
        chk(n_cmd == 0 && n_ld == 0, "R8 strobes", n_cmd + n_ld, 0);
    endtask

    task automatic t_nodata();
        int c0 = n_cmd;
        send_cmd(6'h0B);
        chk(n_cmd == c0 + 1, "R1 count", n_cmd - c0, 1);
        chk(last_cmd == 6'h0B, "R1 code", last_cmd, 6'h0B);
        chk(hi_oe == 1'b0, "R7 oe in cmd", hi_oe, 0);
        send_cmd(6'h35);
        chk(n_cmd == c0 + 2, "R2 count", n_cmd - c0, 2);
        chk(last_cmd == 6'h35, "R2 next code", last_cmd, 6'h35);
    endtask

    task automatic do_load(input logic [13:0] w, input logic ss, output int oe_seen);
        oe_seen = 0;
        send_cmd(6'h02);
        host_clk(ss);
        oe_seen += hi_oe;
        for (int i = 0; i < 14; i++) begin host_clk(w[i]); oe_seen += hi_oe; end
        host_clk(ss);
        oe_seen += hi_oe;
    endtask

    task automatic t_load();
        int l0 = n_ld;
        int oe_cnt;
        do_load(14'h2A5C, 1'b1, oe_cnt);
        chk(n_ld == l0 + 1, "R3 strobe", n_ld - l0, 1);
        chk(last_ld == 14'h2A5C, "R3 data", last_ld, 14'h2A5C);
        chk(oe_cnt == 0, "R7 oe in load", oe_cnt, 0);
        do_load(14'h1555, 1'b0, oe_cnt);
        chk(last_ld == 14'h1555, "R4 start/stop 0", last_ld, 14'h1555);
        do_load(14'h0001, 1'b1, oe_cnt);
        chk(last_ld == 14'h0001, "R4 start/stop 1", last_ld, 14'h0001);
    endtask

    task automatic t_read(input logic [13:0] w);
        int bad_oe = 0;
        int bad_bit = 0;
        logic [13:0] got = '0;
        rd_data = w;
        send_cmd(6'h04);
        host_clk(1'b0);
        chk(hi_oe == 1'b0, "R5 oe off in start slot", hi_oe, 0);
        for (int k = 0; k < 14; k++) begin
            host_clk(1'b0);
            if (!hi_oe) bad_oe++;
            got[k] = hi_dout;
        end
        chk(bad_oe == 0, "R5 oe window", bad_oe, 0);
        chk(got == w, "R6 read word", got, w);
        host_clk(1'b0);
        chk(hi_oe == 1'b0, "R5 oe off at stop", hi_oe, 0);
        bad_bit = (sdat_oe != 1'b0);
        chk(bad_bit == 0, "R7 oe after read", bad_bit, 0);
    endtask

    task automatic t_back_to_back();
        int c0;
        int oe_cnt;
        do_load(14'h3C3A, 1'b0, oe_cnt);
        c0 = n_cmd;
        send_cmd(6'h2D);
        chk(last_ld == 14'h3C3A, "R3 b2b data", last_ld, 14'h3C3A);
        chk(n_cmd == c0 + 1 && last_cmd == 6'h2D, "R2 b2b code", last_cmd, 6'h2D);
    endtask

    task automatic t_abort();
        int c0 = n_cmd;
        host_clk(1'b1); host_clk(1'b1); host_clk(1'b1);
        @(negedge clk) rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(sdat_oe == 1'b0 && n_cmd == c0, "R8 mid reset", n_cmd - c0, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        send_cmd(6'h12);
        chk(n_cmd == c0 + 1 && last_cmd == 6'h12, "R9 fresh cmd", last_cmd, 6'h12);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_nodata();
        t_load();
        t_read(14'h3A96);
        t_read(14'h0C01);
        t_back_to_back();
        t_abort();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule